// File: doc/BRIEF.md
# Interrupt Controller Register Write Filter

This block holds the architectural registers of a local interrupt controller behind an indexed port with one read strobe and one write strobe. It does not simply store what it is given. Each write is filtered by per-register rules:

- In every local vector table entry, two status bits are read-only and keep their stored value.
- The error status register needs a two-write handshake.
- A write to the spurious vector register updates a hidden internal state word. That word can be read at its own index.

Indices that name controller features this block does not provide are refused. Priority, end-of-interrupt, destination, command and timer-count registers are refused, and so are the 16-word in-service, trigger-mode and request arrays. A refused access raises a one-cycle error pulse and leaves storage untouched.

Read data appears one cycle after the read strobe and holds until the next read. The error and warning pulses are also valid one cycle after the strobe that caused them.

Index map (8-bit index):

| Index | Register | Access |
|---|---|---|
| 0x00 | identifier | read/write |
| 0x01 | version | read-only |
| 0x08 | spurious vector | read/write |
| 0x09 | error status | handshake |
| 0x0C to 0x11 | six vector table entries, in the order timer, thermal, perf-counter, local line 0, local line 1, error | filtered write |
| 0x15 | internal state word | read-only |
| anything else | not implemented | refused |

Top module: `lirq_reg_filter`

## Requirements
- R1: After reset, every stored register and the internal state word read as zero. The version register reads VERSION_VALUE (default 0x50014). The error and warning pulses are low.
- R2: A write to the identifier (0x00) or spurious vector (0x08) register stores the full 64-bit value. A read strobe returns the selected value on rdData one cycle later, and rdData holds until the next read strobe.
- R3: A write to any of the six vector table entries (0x0C to 0x11) keeps bits 12 and 14 at their stored values and takes every other bit from the written data.
- R4: A write to the error status register (0x09) while state bit 0 is clear sets state bit 0. The error status value does not change.
- R5: A write to the error status register while state bit 0 is set clears state bit 0 and stores zero into the error status register.
- R6: A read of the error status register clears state bit 0.
- R7: A spurious vector write clears state bit 1 and ORs written bit 8 into state bit 8. The internal state word is readable at index 0x15.
- R8: warnPulse is high for exactly the cycle after a spurious vector write whose data bit 9 is set. It is low otherwise.
- R9: A write to the version register (0x01) is refused: errPulse goes high the next cycle and the version value is unchanged.
- R10: A read or write of any unimplemented index raises errPulse the next cycle. It changes no storage, and a read returns zero. Unimplemented indices are 0x02 to 0x07, 0x0A, 0x0B, 0x12 to 0x14 and 0x20 to 0x4F, plus every other unlisted index.
- R11: A write to the internal state word index (0x15) is refused with errPulse and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| regIdx | input | 8 | Register index |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Read data, updated the cycle after rdEn |
| errPulse | output | 1 | Refused or unimplemented access, one cycle after the strobe |
| warnPulse | output | 1 | Spurious vector write asked for an unsupported focus check |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same cycle. Under that assumption, the clearing of state bit 0 by an error status read and its toggling by a write cannot collide. A separate property checks the assumption itself. The stimulus issues each access as a single-cycle strobe with an idle cycle after it, so read and write never overlap. Every output is compared on every cycle against a behavioural model. The model keeps its own copy of the register contents.

// File: rtl/lirq_pkg.sv
`timescale 1ns/1ps
package lirq_pkg;
  localparam int IDX_W = 8;
  localparam int LVT_N = 6;
  localparam int LVT_SEL_W = 3;

  localparam logic [IDX_W-1:0] IDX_ID    = 8'h00;
  localparam logic [IDX_W-1:0] IDX_VER   = 8'h01;
  localparam logic [IDX_W-1:0] IDX_SPUR  = 8'h08;
  localparam logic [IDX_W-1:0] IDX_ESR   = 8'h09;
  localparam logic [IDX_W-1:0] IDX_LVT0  = 8'h0C;
  localparam logic [IDX_W-1:0] IDX_STATE = 8'h15;

  localparam int FOCUS_BIT = 9;
  localparam int SWEN_BIT  = 8;
  localparam int STALE_BIT = 1;
  localparam int ARM_BIT   = 0;
  localparam int RO_BIT_A  = 12;
  localparam int RO_BIT_B  = 14;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_ID, SEL_VER, SEL_SPUR, SEL_ESR, SEL_LVT, SEL_STATE
  } rdSel_e;

  typedef struct packed {
    logic                 wrId;
    logic                 wrSpur;
    logic                 wrEsr;
    logic                 wrLvt;
    logic [LVT_SEL_W-1:0] lvtIdx;
    logic                 rdEn;
    logic                 rdEsr;
    rdSel_e               rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/lirq_ctrl.sv
`timescale 1ns/1ps
module lirq_ctrl
  import lirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             wrFocus,
  output ctlStrobe_t       ctl,
  output logic             errPulse,
  output logic             warnPulse
);
  logic                 wrOk, rdOk, lvtHit, errNext, warnNext;
  logic [LVT_SEL_W-1:0] lvtSlot;
  rdSel_e               sel;

  always_comb begin
    lvtHit  = 1'b0;
    lvtSlot = '0;
    for (int k = 0; k < LVT_N; k++) begin
      if (regIdx == IDX_LVT0 + IDX_W'(k)) begin
        lvtHit  = 1'b1;
        lvtSlot = LVT_SEL_W'(k);
      end
    end
  end

  always_comb begin
    wrOk = 1'b0;
    rdOk = 1'b0;
    sel  = SEL_ZERO;
    case (regIdx)
      IDX_ID:    begin wrOk = 1'b1; rdOk = 1'b1; sel = SEL_ID;    end
      IDX_VER:   begin              rdOk = 1'b1; sel = SEL_VER;   end
      IDX_SPUR:  begin wrOk = 1'b1; rdOk = 1'b1; sel = SEL_SPUR;  end
      IDX_ESR:   begin wrOk = 1'b1; rdOk = 1'b1; sel = SEL_ESR;   end
      IDX_STATE: begin              rdOk = 1'b1; sel = SEL_STATE; end
      default: begin
        if (lvtHit) begin
          wrOk = 1'b1;
          rdOk = 1'b1;
          sel  = SEL_LVT;
        end
      end
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.wrId   = wrEn && (regIdx == IDX_ID);
    ctl.wrSpur = wrEn && (regIdx == IDX_SPUR);
    ctl.wrEsr  = wrEn && (regIdx == IDX_ESR);
    ctl.wrLvt  = wrEn && lvtHit;
    ctl.lvtIdx = lvtSlot;
    ctl.rdEn   = rdEn;
    ctl.rdEsr  = rdEn && (regIdx == IDX_ESR);
    ctl.rdSel  = rdOk ? sel : SEL_ZERO;
    errNext    = (wrEn && !wrOk) || (rdEn && !rdOk);
    warnNext   = wrEn && (regIdx == IDX_SPUR) && wrFocus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPulse  <= 1'b0;
      warnPulse <= 1'b0;
    end else begin
      errPulse  <= errNext;
      warnPulse <= warnNext;
    end
  end

  assert_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn));

  // R9 / R10 / R11: an error pulse always follows a strobe
  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(wrEn || rdEn));

  assert_warn_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    warnPulse |-> $past(wrEn && (regIdx == IDX_SPUR) && wrFocus));
endmodule

// File: rtl/lirq_datapath.sv
`timescale 1ns/1ps
module lirq_datapath
  import lirq_pkg::*;
#(
  parameter int                DATA_W        = 64,
  parameter logic [DATA_W-1:0] VERSION_VALUE = DATA_W'(32'h0005_0014)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [DATA_W-1:0] RO_MASK =
    (DATA_W'(1) << RO_BIT_A) | (DATA_W'(1) << RO_BIT_B);
  localparam logic [DATA_W-1:0] STALE_MASK = DATA_W'(1) << STALE_BIT;
  localparam logic [DATA_W-1:0] SWEN_MASK  = DATA_W'(1) << SWEN_BIT;

  logic [DATA_W-1:0] idQ, spurQ, esrQ, stateQ, rdNext;
  logic [DATA_W-1:0] lvtQ [LVT_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idQ   <= '0;
      spurQ <= '0;
    end else begin
      if (ctl.wrId)   idQ   <= wrData;
      if (ctl.wrSpur) spurQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= '0;
      esrQ   <= '0;
    end else if (ctl.wrSpur) begin
      stateQ <= (stateQ & ~STALE_MASK) | (wrData & SWEN_MASK);
    end else if (ctl.wrEsr) begin
      if (stateQ[ARM_BIT]) begin
        stateQ[ARM_BIT] <= 1'b0;
        esrQ            <= '0;
      end else begin
        stateQ[ARM_BIT] <= 1'b1;
      end
    end else if (ctl.rdEsr) begin
      stateQ[ARM_BIT] <= 1'b0;
    end
  end

  for (genvar i = 0; i < LVT_N; i++) begin : g_lvt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lvtQ[i] <= '0;
      end else if (ctl.wrLvt && (ctl.lvtIdx == LVT_SEL_W'(i))) begin
        lvtQ[i] <= (wrData & ~RO_MASK) | (lvtQ[i] & RO_MASK);
      end
    end

    assert_lvt_ro_R3: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.wrLvt && (ctl.lvtIdx == LVT_SEL_W'(i))) |=>
        ((lvtQ[i] & RO_MASK) == ($past(lvtQ[i]) & RO_MASK)));
  end

  always_comb begin
    case (ctl.rdSel)
      SEL_ID:    rdNext = idQ;
      SEL_VER:   rdNext = VERSION_VALUE;
      SEL_SPUR:  rdNext = spurQ;
      SEL_ESR:   rdNext = esrQ;
      SEL_LVT:   rdNext = lvtQ[ctl.lvtIdx];
      SEL_STATE: rdNext = stateQ;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (ctl.rdEn) rdData <= rdNext;
  end

  assert_esr_arm_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEsr && !ctl.wrSpur && !stateQ[ARM_BIT]) |=>
      (stateQ[ARM_BIT] && $stable(esrQ)));

  assert_esr_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEsr && !ctl.wrSpur && stateQ[ARM_BIT]) |=>
      (!stateQ[ARM_BIT] && (esrQ == '0)));

  assert_esr_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdEsr && !ctl.wrEsr && !ctl.wrSpur) |=> !stateQ[ARM_BIT]);

  assert_spur_state_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrSpur |=> (!stateQ[STALE_BIT] &&
      (stateQ[SWEN_BIT] == ($past(stateQ[SWEN_BIT]) | $past(wrData[SWEN_BIT])))));

  assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdEn |=> $stable(rdData));
endmodule

// File: rtl/lirq_reg_filter.sv
`timescale 1ns/1ps
module lirq_reg_filter
  import lirq_pkg::*;
#(
  parameter int                DATA_W        = 64,
  parameter logic [DATA_W-1:0] VERSION_VALUE = DATA_W'(32'h0005_0014)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              errPulse,
  output logic              warnPulse
);
  ctlStrobe_t ctl;

  lirq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .regIdx    (regIdx),
    .wrFocus   (wrData[FOCUS_BIT]),
    .ctl       (ctl),
    .errPulse  (errPulse),
    .warnPulse (warnPulse)
  );

  lirq_datapath #(
    .DATA_W        (DATA_W),
    .VERSION_VALUE (VERSION_VALUE)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: tb/test_lirq_reg_filter.sv
`timescale 1ns/1ps
module test_lirq_reg_filter;
  localparam logic [63:0] VER = 64'h0005_0014;
  localparam logic [63:0] RO  = 64'h0000_0000_0000_5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  regIdx = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        errPulse, warnPulse;

  int    checks = 0;
  int    errors = 0;
  bit    cmpOn = 1'b0;
  string curReq = "R1";

  logic [63:0] mId, mSpur, mEsr, mState, mRd;
  logic [63:0] mLvt [6];
  logic        mErr, mWarn;

  always #2.5 clk = ~clk;

  lirq_reg_filter i_lirq_reg_filter (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regIdx(regIdx),
    .wrData(wrData), .rdData(rdData), .errPulse(errPulse), .warnPulse(warnPulse)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mId = 0; mSpur = 0; mEsr = 0; mState = 0; mRd = 0; mErr = 0; mWarn = 0;
      for (int k = 0; k < 6; k++) mLvt[k] = 0;
    end else begin
      mErr = 0; mWarn = 0;
      if (wrEn) begin
        if (regIdx == 8'h00) mId = wrData;
        else if (regIdx == 8'h08) begin
          mSpur = wrData;
          mState[1] = 1'b0;
          if (wrData[8]) mState[8] = 1'b1;
          if (wrData[9]) mWarn = 1'b1;
        end else if (regIdx == 8'h09) begin
          if (mState[0]) begin mState[0] = 1'b0; mEsr = 0; end
          else mState[0] = 1'b1;
        end else if (regIdx >= 8'h0C && regIdx <= 8'h11)
          mLvt[regIdx - 8'h0C] = (wrData & ~RO) | (mLvt[regIdx - 8'h0C] & RO);
        else mErr = 1'b1;
      end
      if (rdEn) begin
        if (regIdx == 8'h00) mRd = mId;
        else if (regIdx == 8'h01) mRd = VER;
        else if (regIdx == 8'h08) mRd = mSpur;
        else if (regIdx == 8'h09) begin mRd = mEsr; mState[0] = 1'b0; end
        else if (regIdx >= 8'h0C && regIdx <= 8'h11) mRd = mLvt[regIdx - 8'h0C];
        else if (regIdx == 8'h15) mRd = mState;
        else begin mRd = 0; mErr = 1'b1; end
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      chk("rdData", rdData, mRd);
      chk("errPulse", 64'(errPulse), 64'(mErr));
      chk("warnPulse", 64'(warnPulse), 64'(mWarn));
    end
  end

  task automatic acc(input bit w, input bit r, input logic [7:0] idx,
                     input logic [63:0] d, input string req);
    curReq = req;
    @(negedge clk);
    wrEn = w; rdEn = r; regIdx = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [63:0] d, input string req);
    acc(1'b1, 1'b0, idx, d, req);
  endtask

  task automatic rd(input logic [7:0] idx, input string req);
    acc(1'b0, 1'b1, idx, 64'h0, req);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    cmpOn = 1'b1;
    // R1: reset values
    rd(8'h00, "R1"); rd(8'h01, "R1"); rd(8'h08, "R1"); rd(8'h09, "R1");
    rd(8'h15, "R1");
    for (int k = 0; k < 6; k++) rd(8'h0C + 8'(k), "R1");
    // R2: plain storage and read hold
    wr(8'h00, 64'h0123_4567_89AB_CDEF, "R2");
    rd(8'h00, "R2");
    wr(8'h00, 64'hFEDC_BA98_7654_3210, "R2");
    repeat (3) @(negedge clk);
    rd(8'h00, "R2");
    // R3: vector table filtering
    for (int k = 0; k < 6; k++) begin
      wr(8'h0C + 8'(k), 64'hFFFF_FFFF_FFFF_FFFF, "R3");
      rd(8'h0C + 8'(k), "R3");
      wr(8'h0C + 8'(k), 64'h5555_AAAA_0000_5A5A ^ 64'(k), "R3");
      rd(8'h0C + 8'(k), "R3");
    end
    // R4 / R5: two-step error status handshake
    rd(8'h15, "R4");
    wr(8'h09, 64'hDEAD_BEEF, "R4");
    rd(8'h15, "R4");
    wr(8'h09, 64'h1234, "R5");
    rd(8'h15, "R5");
    rd(8'h09, "R5");
    // R6: read of error status disarms
    wr(8'h09, 64'h77, "R6");
    rd(8'h09, "R6");
    rd(8'h15, "R6");
    wr(8'h09, 64'h1, "R6");
    rd(8'h15, "R6");
    // R7: spurious vector side effect on state
    wr(8'h08, 64'h0000_0000_0000_00FF, "R7");
    rd(8'h15, "R7");
    wr(8'h08, 64'h0000_0000_0000_01FF, "R7");
    rd(8'h15, "R7");
    rd(8'h08, "R7");
    wr(8'h08, 64'h0000_0000_0000_0003, "R7");
    rd(8'h15, "R7");
    // R8: focus warning
    wr(8'h08, 64'h0000_0000_0000_0200, "R8");
    wr(8'h08, 64'h0000_0000_0000_0100, "R8");
    rd(8'h08, "R8");
    // R9: version is read-only
    wr(8'h01, 64'hFFFF, "R9");
    rd(8'h01, "R9");
    // R10: unimplemented indices
    for (int i = 2; i < 8; i++) begin wr(8'(i), 64'hAAAA, "R10"); rd(8'(i), "R10"); end
    wr(8'h0A, 64'h1, "R10"); rd(8'h0B, "R10");
    for (int i = 8'h12; i <= 8'h14; i++) begin wr(8'(i), 64'h5, "R10"); rd(8'(i), "R10"); end
    for (int i = 8'h20; i < 8'h50; i += 5) begin wr(8'(i), 64'h9, "R10"); rd(8'(i), "R10"); end
    wr(8'hFF, 64'h3, "R10"); rd(8'h16, "R10");
    rd(8'h00, "R10"); rd(8'h15, "R10"); rd(8'h0C, "R10");
    // R11: state word is read-only
    wr(8'h15, 64'hFFFF_FFFF_FFFF_FFFF, "R11");
    rd(8'h15, "R11");
    repeat (2) @(negedge clk);
    cmpOn = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule